// File: doc/BRIEF.md
# Two-Way Write-Through Data Cache

This block is a small data cache placed between a processor load/store port and a lower memory. It holds 64 sets of two lines each, and every line holds one 16-byte block of four 32-bit words. Each line carries its own stored tag and one valid flag. A lookup uses the set field of the address to choose a set and compares the address tag with the tag of both ways. Read hits complete in the cycle they are presented. A read miss fetches the whole block from lower memory, one word per beat, installs it in the way chosen by a per-set least-recently-used bit, and then completes the read.

Stores never stay only in the cache. Every accepted store is handed to a downstream write buffer as an address/data pair, and also updates the cached copy when the block is present. An input selects what a store miss does: with allocation on, the block is fetched first and then updated; with allocation off, only the write buffer sees the store and the cache is left alone. When the write buffer reports full, the store waits and its request stays on the buffer port.

Top module: `cacheWt`

## Requirements
- R1: Word address bits [3:2] pick the word within a block, bits [9:4] pick the set, bits [31:10] form the tag; byte bits [1:0] do not affect which word is read.
- R2: A line is a hit only when its valid flag is 1 and its stored tag equals the address tag; reset clears every valid flag, so the first access to any address (including address 0) is a miss.
- R3: A read hit raises cpuReady in the cycle the request is presented (with cpuReq high and memReq low), cpuRdata carries the word, and no lower-memory request is made.
- R4: A read miss raises memReq with the block-aligned address (memAddr[3:0] = 0); the block arrives as four memRvalid beats, word 0 first; cpuReady stays low while memReq is high, and the read completes with the fetched word after the fill.
- R5: Two blocks with the same set field and different tags are held at once; after both are fetched, reads to either hit.
- R6: When a miss meets a set with both lines valid, the line replaced is the one not touched most recently by a hit or fill.
- R7: Every accepted store raises wbValid with wbAddr and wbData equal to the request in the completing cycle; a store hit also updates the cached word, so a later read returns the stored value.
- R8: With allocOnWrite = 1, a store miss first fetches the block (one fill), then completes as a store hit, leaving the rest of the block readable without a further fill.
- R9: With allocOnWrite = 0, a store miss makes no lower-memory read and leaves the cache contents unchanged; a later read of that block misses.
- R10: While wbFull is 1, a pending store keeps wbValid high with stable wbAddr and wbData and cpuReady low; it completes once wbFull falls.
- R11: Read requests, hits or misses, never raise wbValid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| allocOnWrite | input | 1 | 1: fetch block on store miss; 0: store miss bypasses the cache |
| cpuReq | input | 1 | Processor request, held until cpuReady |
| cpuWe | input | 1 | 1 for a store, 0 for a read |
| cpuAddr | input | 32 | Byte address of the request |
| cpuWdata | input | 32 | Store data |
| cpuReady | output | 1 | Request completes at this rising edge |
| cpuRdata | output | 32 | Read data, valid with cpuReady on a read |
| memReq | output | 1 | Block fetch in progress |
| memAddr | output | 32 | Block-aligned fetch address |
| memRvalid | input | 1 | One fetched word is present on memRdata |
| memRdata | input | 32 | Fetched word, in ascending word order |
| wbValid | output | 1 | Store offered to the write buffer |
| wbFull | input | 1 | Write buffer cannot take a store this cycle |
| wbAddr | output | 32 | Store address to the write buffer |
| wbData | output | 32 | Store data to the write buffer |

## Verification
Reads are tried on an empty cache (address 0, whose reset tag would match if validity were ignored), on a block just fetched at a different word and byte offset, and on three blocks sharing one set, which separates correct replacement from replacing the most recent line or always one fixed way. Stores are tried as hits, as misses under each allocation setting and against a full write buffer; the fill count and later read results tell allocation from bypass, and the buffer log confirms that every store and no read reaches the lower level.

// File: rtl/cache_pkg.sv
package cache_pkg;
  localparam int WAYS = 2;

  typedef struct packed {
    logic fillWrite;
    logic fillDone;
    logic storeWrite;
    logic touch;
  } ctrlStrobes_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } ctrlState_t;
endpackage

// File: rtl/cacheDatapath.sv
module cacheDatapath
  import cache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int SETS   = 64
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  ctrlStrobes_t                         strb,
  input  logic [ADDR_W-$clog2(DATA_W/8)-1:0]   wordAddr,
  input  logic [DATA_W-1:0]                    cpuWdata,
  input  logic [DATA_W-1:0]                    memRdata,
  input  logic [$clog2(WORDS)-1:0]             fillIdx,
  input  logic                                 victimWay,
  output logic                                 hit,
  output logic                                 victimSel,
  output logic [DATA_W-1:0]                    rdata
);
  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int WIDX_W = $clog2(WORDS);
  localparam int IDX_W  = $clog2(SETS);
  localparam int WA_W   = ADDR_W - BYTE_W;
  localparam int TAG_W  = WA_W - WIDX_W - IDX_W;

  logic [WIDX_W-1:0] wordSel;
  logic [IDX_W-1:0]  setIdx;
  logic [TAG_W-1:0]  addrTag;
  logic [WAYS-1:0]   hitVec;
  logic [WAYS-1:0]   validHere;
  logic [DATA_W-1:0] wayData [WAYS];
  logic [SETS-1:0]   lruBits;
  logic              hitWay;

  assign wordSel = wordAddr[WIDX_W-1:0];
  assign setIdx  = wordAddr[WIDX_W +: IDX_W];
  assign addrTag = wordAddr[WA_W-1 -: TAG_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0]  tagMem  [SETS];
    logic [SETS-1:0]   validMem;
    logic [DATA_W-1:0] dataMem [SETS][WORDS];
    logic              isVictim;

    assign isVictim     = (victimWay == w[0]);
    assign validHere[w] = validMem[setIdx];
    assign hitVec[w]    = validMem[setIdx] && (tagMem[setIdx] == addrTag);
    assign wayData[w]   = dataMem[setIdx][wordSel];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        validMem <= '0;
        for (int s = 0; s < SETS; s++) tagMem[s] <= '0;
      end else if (strb.fillDone && isVictim) begin
        validMem[setIdx] <= 1'b1;
        tagMem[setIdx]   <= addrTag;
      end
    end

    always_ff @(posedge clk) begin
      if (strb.fillWrite && isVictim)
        dataMem[setIdx][fillIdx] <= memRdata;
      else if (strb.storeWrite && hitVec[w])
        dataMem[setIdx][wordSel] <= cpuWdata;
    end
  end

  assign hit    = |hitVec;
  assign hitWay = hitVec[1];
  assign rdata  = hitWay ? wayData[1] : wayData[0];

  always_comb begin
    if (!validHere[0])      victimSel = 1'b0;
    else if (!validHere[1]) victimSel = 1'b1;
    else                    victimSel = lruBits[setIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN)              lruBits <= '0;
    else if (strb.fillDone) lruBits[setIdx] <= ~victimWay;
    else if (strb.touch)    lruBits[setIdx] <= ~hitWay;
  end
endmodule

// File: rtl/cacheControl.sv
module cacheControl
  import cache_pkg::*;
#(
  parameter int WORDS = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cpuReq,
  input  logic                     cpuWe,
  input  logic                     allocOnWrite,
  input  logic                     wbFull,
  input  logic                     hit,
  input  logic                     victimSel,
  input  logic                     memRvalid,
  output ctrlStrobes_t             strb,
  output logic [$clog2(WORDS)-1:0] fillIdx,
  output logic                     victimWay,
  output logic                     cpuReady,
  output logic                     wbValid,
  output logic                     memReq
);
  localparam int WIDX_W = $clog2(WORDS);
  localparam logic [WIDX_W-1:0] LAST_IDX = WIDX_W'(WORDS - 1);

  ctrlState_t state;
  logic lookup, readDone, storeGo, missStart;

  always_comb begin
    lookup    = (state == ST_IDLE) && cpuReq;
    readDone  = lookup && !cpuWe && hit;
    storeGo   = lookup && cpuWe && (hit || !allocOnWrite);
    missStart = lookup && !hit && (!cpuWe || allocOnWrite);

    wbValid  = storeGo;
    cpuReady = readDone || (storeGo && !wbFull);
    memReq   = (state == ST_FILL);

    strb.fillWrite  = memReq && memRvalid;
    strb.fillDone   = strb.fillWrite && (fillIdx == LAST_IDX);
    strb.storeWrite = storeGo && !wbFull && hit;
    strb.touch      = readDone || strb.storeWrite;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      fillIdx   <= '0;
      victimWay <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (missStart) begin
          state     <= ST_FILL;
          victimWay <= victimSel;
          fillIdx   <= '0;
        end
        ST_FILL: if (memRvalid) begin
          fillIdx <= fillIdx + 1'b1;
          if (fillIdx == LAST_IDX) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cacheWt.sv
module cacheWt
  import cache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int SETS   = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              allocOnWrite,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuReady,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memRvalid,
  input  logic [DATA_W-1:0] memRdata,
  output logic              wbValid,
  input  logic              wbFull,
  output logic [ADDR_W-1:0] wbAddr,
  output logic [DATA_W-1:0] wbData
);
  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int OFF_W  = $clog2(WORDS) + BYTE_W;

  ctrlStrobes_t             strb;
  logic [$clog2(WORDS)-1:0] fillIdx;
  logic                     victimWay, victimSel, hit;

  assign memAddr = {cpuAddr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign wbAddr  = cpuAddr;
  assign wbData  = cpuWdata;

  cacheControl #(.WORDS(WORDS)) ctrl_i (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe),
    .allocOnWrite(allocOnWrite), .wbFull(wbFull), .hit(hit),
    .victimSel(victimSel), .memRvalid(memRvalid), .strb(strb),
    .fillIdx(fillIdx), .victimWay(victimWay), .cpuReady(cpuReady),
    .wbValid(wbValid), .memReq(memReq)
  );

  cacheDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .SETS(SETS)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .wordAddr(cpuAddr[ADDR_W-1:BYTE_W]), .cpuWdata(cpuWdata),
    .memRdata(memRdata), .fillIdx(fillIdx), .victimWay(victimWay),
    .hit(hit), .victimSel(victimSel), .rdata(cpuRdata)
  );
endmodule

// File: rtl/cacheWtChecker.sv
module cacheWtChecker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              allocOnWrite,
  input logic              cpuWe,
  input logic              cpuReady,
  input logic              memReq,
  input logic [ADDR_W-1:0] memAddr,
  input logic              wbValid,
  input logic              wbFull,
  input logic [ADDR_W-1:0] wbAddr,
  input logic [DATA_W-1:0] wbData
);
  // R4: the processor is held while a block is being fetched
  p_no_ready_in_fill_r4: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !cpuReady);

  // R4: fetch address is block aligned
  p_fill_aligned_r4: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddr[3:0] == 4'h0));

  // R9: a fetch never starts for a store under write-around
  p_around_no_fill_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memReq) |-> (!cpuWe || allocOnWrite));

  // R10: a blocked store holds its offer steady
  p_wb_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && wbFull) |=> (wbValid && $stable(wbAddr) && $stable(wbData)));

  // R10: no store completes against a full buffer
  p_full_stalls_r10: assert property (@(posedge clk) disable iff (!rstN)
    wbFull |-> !(cpuReady && cpuWe));

  // R11: reads never reach the write buffer
  p_read_no_wb_r11: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> cpuWe);
endmodule

bind cacheWt cacheWtChecker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .allocOnWrite(allocOnWrite), .cpuWe(cpuWe),
  .cpuReady(cpuReady), .memReq(memReq), .memAddr(memAddr),
  .wbValid(wbValid), .wbFull(wbFull), .wbAddr(wbAddr), .wbData(wbData)
);

// File: tb/cacheWt_tb_top.sv
`timescale 1ns/1ps
module cacheWt_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        allocOnWrite = 1'b0;
  logic        cpuReq = 1'b0, cpuWe = 1'b0;
  logic [31:0] cpuAddr = '0, cpuWdata = '0;
  logic        cpuReady, memReq, wbValid;
  logic [31:0] cpuRdata, memAddr, wbAddr, wbData;
  logic        memRvalid = 1'b0;
  logic [31:0] memRdata = '0;
  logic        wbFull = 1'b0;

  int checks = 0, fails = 0;
  int fillCount = 0, wbCount = 0, readyInFill = 0;
  logic [31:0] lastWbAddr = '0, lastWbData = '0;
  logic [31:0] memOvr [logic [31:0]];

  always #2 clk = ~clk;

  cacheWt dut_i (
    .clk(clk), .rstN(rstN), .allocOnWrite(allocOnWrite), .cpuReq(cpuReq),
    .cpuWe(cpuWe), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuReady(cpuReady),
    .cpuRdata(cpuRdata), .memReq(memReq), .memAddr(memAddr),
    .memRvalid(memRvalid), .memRdata(memRdata), .wbValid(wbValid),
    .wbFull(wbFull), .wbAddr(wbAddr), .wbData(wbData)
  );

  function automatic logic [31:0] memVal(input logic [31:0] a);
    logic [31:0] k = {a[31:2], 2'b00};
    if (memOvr.exists(k)) return memOvr[k];
    return (k * 32'd7) ^ 32'hC3A5_0F1E;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // lower memory: three cycles of latency, then four beats in word order
  initial begin
    int reqCycles = 0, beat = 0;
    forever begin
      @(negedge clk);
      if (memReq) begin
        reqCycles++;
        if (reqCycles >= 3 && beat < 4) begin
          memRvalid = 1'b1;
          memRdata  = memVal(memAddr + 32'(beat * 4));
          beat++;
        end else memRvalid = 1'b0;
      end else begin
        reqCycles = 0; beat = 0; memRvalid = 1'b0;
      end
    end
  end

  // observers: fills, write-buffer transfers, ready during fill
  initial begin
    logic prevReq = 1'b0;
    forever begin
      @(negedge clk); #2;
      if (memReq && !prevReq) fillCount++;
      prevReq = memReq;
      if (memReq && cpuReady) readyInFill++;
      if (wbValid && !wbFull && cpuReady) begin
        wbCount++;
        lastWbAddr = wbAddr; lastWbData = wbData;
        memOvr[{wbAddr[31:2], 2'b00}] = wbData;
      end
    end
  end

  task automatic access(input logic we, input logic [31:0] a, input logic [31:0] d, output logic [31:0] rd);
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = we; cpuAddr = a; cpuWdata = d;
    forever begin
      #1;
      if (cpuReady) break;
      @(negedge clk);
    end
    rd = cpuRdata;
    @(negedge clk);
    cpuReq = 1'b0; cpuWe = 1'b0;
  endtask

  task automatic readExpect(input logic [31:0] a, input logic [31:0] exp, input int fillDelta, input string req);
    logic [31:0] rd;
    int f0 = fillCount, w0 = wbCount;
    access(1'b0, a, '0, rd);
    check(rd == exp, req, rd, exp);
    check(fillCount - f0 == fillDelta, {req, " fill count"}, 32'(fillCount - f0), 32'(fillDelta));
    check(wbCount == w0, "R11 read made no store", 32'(wbCount - w0), 0);
  endtask

  task automatic storeExpect(input logic [31:0] a, input logic [31:0] d, input int fillDelta, input string req);
    logic [31:0] rd;
    int f0 = fillCount, w0 = wbCount;
    access(1'b1, a, d, rd);
    check(wbCount - w0 == 1, {req, " R7 one buffer transfer"}, 32'(wbCount - w0), 1);
    check(lastWbAddr == a && lastWbData == d, {req, " R7 buffer payload"}, lastWbData, d);
    check(fillCount - f0 == fillDelta, {req, " fill count"}, 32'(fillCount - f0), 32'(fillDelta));
  endtask

  task automatic testReset();
    #1;
    check(cpuReady == 1'b0 && memReq == 1'b0 && wbValid == 1'b0, "R2 idle after reset",
          {29'd0, cpuReady, memReq, wbValid}, 0);
    // address 0: reset tag is 0, valid is 0 -> must miss (R2)
    readExpect(32'h0000_0000, memVal(32'h0), 1, "R2 invalid line misses");
  endtask

  task automatic testReadPath();
    readExpect(32'h0000_0458, memVal(32'h458), 1, "R4 read miss fill");
    readExpect(32'h0000_0450, memVal(32'h450), 0, "R3 read hit word 0");
    readExpect(32'h0000_045F, memVal(32'h45C), 0, "R1 word 3 with byte offset");
    check(readyInFill == 0, "R4 ready low during fill", 32'(readyInFill), 0);
  endtask

  task automatic testWaysAndLru();
    // set 5: A=0x450 (cached), B=0x850, C=0xC50
    readExpect(32'h0000_0850, memVal(32'h850), 1, "R5 second way miss");
    readExpect(32'h0000_0454, memVal(32'h454), 0, "R5 first block still held");
    readExpect(32'h0000_0854, memVal(32'h854), 0, "R5 second block still held");
    readExpect(32'h0000_0450, memVal(32'h450), 0, "R6 touch A");
    readExpect(32'h0000_0C50, memVal(32'hC50), 1, "R6 third block miss");
    readExpect(32'h0000_0450, memVal(32'h450), 0, "R6 recent line kept");
    readExpect(32'h0000_0850, memVal(32'h850), 1, "R6 least recent line replaced");
  endtask

  task automatic testStoreHit();
    // A evicted last step? B replaced C (C older than A): A is present
    storeExpect(32'h0000_0458, 32'hDEAD_0001, 0, "R7 store hit");
    readExpect(32'h0000_0458, 32'hDEAD_0001, 0, "R7 cached copy updated");
  endtask

  task automatic testWriteAround();
    allocOnWrite = 1'b0;
    storeExpect(32'h0000_1070, 32'h1234_5678, 0, "R9 write-around store miss");
    readExpect(32'h0000_1074, memVal(32'h1074), 1, "R9 block was not installed");
    readExpect(32'h0000_1070, 32'h1234_5678, 0, "R9 lower memory got store");
  endtask

  task automatic testWriteAllocate();
    allocOnWrite = 1'b1;
    storeExpect(32'h0000_20A4, 32'hABCD_EF01, 1, "R8 allocate store miss");
    readExpect(32'h0000_20A8, memVal(32'h20A8), 0, "R8 rest of block present");
    readExpect(32'h0000_20A4, 32'hABCD_EF01, 0, "R8 stored word in cache");
    allocOnWrite = 1'b0;
  endtask

  task automatic testFullStall();
    logic [31:0] rd;
    int w0 = wbCount;
    int stallBad = 0;
    @(negedge clk);
    wbFull = 1'b1;
    cpuReq = 1'b1; cpuWe = 1'b1; cpuAddr = 32'h0000_20A8; cpuWdata = 32'h5555_AAAA;
    for (int i = 0; i < 5; i++) begin
      #1;
      if (cpuReady || !wbValid || wbAddr != 32'h0000_20A8) stallBad++;
      @(negedge clk);
    end
    check(stallBad == 0, "R10 store held while full", 32'(stallBad), 0);
    check(wbCount == w0, "R10 nothing accepted while full", 32'(wbCount - w0), 0);
    wbFull = 1'b0;
    forever begin
      #1;
      if (cpuReady) break;
      @(negedge clk);
    end
    @(negedge clk);
    cpuReq = 1'b0; cpuWe = 1'b0;
    check(wbCount - w0 == 1 && lastWbData == 32'h5555_AAAA, "R10 store completes after full",
          lastWbData, 32'h5555_AAAA);
    readExpect(32'h0000_20A8, 32'h5555_AAAA, 0, "R10 cache updated once accepted");
    rd = '0;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testReadPath();
    testWaysAndLru();
    testStoreHit();
    testWriteAround();
    testWriteAllocate();
    testFullStall();
    check(readyInFill == 0, "R4 ready never high during fill", 32'(readyInFill), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule